// File: doc/BRIEF.md
# Serial Flash Block-Erase Command Front End

This block is the device-side command logic of a serial NOR flash that takes a 64 KB block-erase request over a four-wire SPI link and keeps the two status flags that govern it. The SPI pins are oversampled in the system clock domain. Serial data is captured on rising serial-clock edges while chip select is low. An 8-bit opcode and then a 24-bit address are assembled, most significant bit first. SPI modes 0 and 3 are both accepted. A separate write-enable command arms a write-enable flag. A status-read command shifts a status byte back on the output line, so the host can poll for completion.

A block erase is launched only when all of the following hold. The frame is exactly 32 bits long when chip select returns high. The write-enable flag is set. The addressed block is not covered by the protection setting on `prot_cfg`. No erase is running. The array itself is not modelled. A launched erase emits a one-cycle strobe together with the block index and then runs a self-timed busy period of `ERASE_CYCLES` system clocks. At the end of that period the write-enable flag is cleared.

Top module: `spi_erase_ctl`

## Requirements
- R1: After reset the status byte reads 00h, `spi_miso_oe` is 0, and no erase strobe has been issued.
- R2: Opcode 06h, in a frame of exactly 8 bits, sets the write-enable flag, which is status bit 1. A frame of any other length with that opcode has no effect.
- R3: With opcode 05h, every falling serial-clock edge after the 8th bit drives the next status bit on `spi_miso`, MSB first. The byte holds busy in bit 0, write-enable in bit 1 and zeros in bits 7..2. The byte repeats for as long as the clocks continue. `spi_miso_oe` is 1 only while these bits are driven and is 0 in the cycle after chip select is seen high.
- R4: Opcode D8h, followed by a 24-bit address and ending exactly at bit 32, produces a single-cycle `erase_strobe`. `erase_blk` then equals address bits [16+BLK_W-1:16]. Address bits above those are ignored.
- R5: A D8h frame whose chip select rises after any bit count other than 32 (for example 24, 31 or 33) issues no strobe and leaves both status flags unchanged.
- R6: A D8h frame received while the write-enable flag is 0 issues no strobe.
- R7: `prot_cfg` holds bp in [2:0], tb in [3], sec in [4] and cmp in [5]. Let n = 2^BLK_W be the number of blocks. The protected count is 0 when bp = 0. Otherwise it is 1 when sec = 1, and otherwise min(2^(bp-1), n). These blocks are counted from the top of the array when tb = 0 and from block 0 when tb = 1. When cmp = 1 the protected and unprotected sets swap. An erase aimed at a protected block issues no strobe and keeps the write-enable flag.
- R8: Status busy reads 1 from the strobe until `ERASE_CYCLES` clocks later and then reads 0. The write-enable flag is cleared at that point.
- R9: While busy is 1, every opcode except 05h is ignored, including a second D8h. `erase_blk` holds its value for the whole busy period.
- R10: SPI mode 0 (serial clock idles low) and SPI mode 3 (serial clock idles high) decode identically.
- R11: A 32-bit frame with an opcode other than D8h, 06h or 05h has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | Serial clock from host |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data from host |
| prot_cfg | input | 6 | Protection setting {cmp, sec, tb, bp[2:0]} |
| spi_miso | output | 1 | Serial data to host |
| spi_miso_oe | output | 1 | Output enable for `spi_miso`; 0 means high impedance |
| erase_strobe | output | 1 | One-cycle erase launch pulse |
| erase_blk | output | BLK_W | Index of the block being erased |

## Verification
Block-erase frames are sent with lengths of 24, 31, 32 and 33 bits. Only the 32-bit length may launch an erase, so these frames separate the exact-boundary rule from a "long enough" rule. The same address is sent with and without a prior write enable. Blocks that sit on either side of the protection edge are tried under top, bottom, complemented, sector and whole-array settings, which pins down the edge of each region. Address patterns with set upper bits and frames in both clock polarities show that only A[16+BLK_W-1:16] selects the block and that modes 0 and 3 decode identically. Commands issued during a running erase show that only the status read is still served.

// File: rtl/spi_erase_pkg.sv
package spi_erase_pkg;

  localparam logic [7:0] OPC_ERASE = 8'hD8;
  localparam logic [7:0] OPC_WEN   = 8'h06;
  localparam logic [7:0] OPC_RDSR  = 8'h05;
  localparam int ERASE_FRAME_BITS  = 32;
  localparam int WEN_FRAME_BITS    = 8;

  typedef struct packed {
    logic       cmp;
    logic       sec;
    logic       tb;
    logic [2:0] bp;
  } prot_t;

  // Returns 1 when block blk of a 2**blk_w array is write protected.
  function automatic logic blk_locked(input logic [7:0] blk, input prot_t p,
                                      input int unsigned blk_w);
    int unsigned nblk;
    int unsigned cnt;
    int unsigned bpv;
    int unsigned b;
    logic        hit;
    b    = 32'(blk);
    bpv  = 32'(p.bp);
    nblk = 32'd1 << blk_w;
    if (bpv == 0)               cnt = 0;
    else if (p.sec)             cnt = 1;
    else if (bpv - 1 >= blk_w)  cnt = nblk;
    else                        cnt = 32'd1 << (bpv - 1);
    hit = p.tb ? (b < cnt) : (b + cnt >= nblk);
    return hit ^ p.cmp;
  endfunction

  function automatic logic [7:0] status_byte(input logic busy, input logic wel);
    return {6'b000000, wel, busy};
  endfunction

endpackage

// File: rtl/spi_erase_sync.sv
module spi_erase_sync #(
  parameter int          N       = 3,
  parameter int          STAGES  = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] din,
  output logic [N-1:0] dout
);

  for (genvar i = 0; i < N; i++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL[i]}};
      else        chain <= {chain[STAGES-2:0], din[i]};
    end
    assign dout[i] = chain[STAGES-1];
  end

endmodule

// File: rtl/spi_erase_frame.sv
module spi_erase_frame #(
  parameter int BLK_W = 4,
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sclk_rise,
  input  logic             cs_fall,
  input  logic             cs_low,
  input  logic             mosi,
  output logic [CNT_W-1:0] bit_cnt,
  output logic [7:0]       opc,
  output logic [BLK_W-1:0] blk
);

  localparam int SH_W = 16 + BLK_W;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [SH_W-1:0] shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt <= '0;
      opc     <= '0;
      shreg   <= '0;
    end else if (cs_fall) begin
      bit_cnt <= '0;
      opc     <= '0;
    end else if (sclk_rise && cs_low) begin
      shreg <= {shreg[SH_W-2:0], mosi};
      if (bit_cnt != CNT_MAX) bit_cnt <= bit_cnt + 1'b1;
      if (bit_cnt == CNT_W'(7)) opc <= {shreg[6:0], mosi};
    end
  end

  // After a full frame the oldest retained bits are the block-select bits.
  assign blk = shreg[SH_W-1 -: BLK_W];

endmodule

// File: rtl/spi_erase_tx.sv
module spi_erase_tx (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sclk_fall,
  input  logic       cs_low,
  input  logic       rd_phase,
  input  logic [7:0] status_live,
  output logic       miso,
  output logic       miso_oe
);

  logic [2:0] idx;
  logic [7:0] snap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx     <= '0;
      snap    <= '0;
      miso    <= 1'b0;
      miso_oe <= 1'b0;
    end else if (!cs_low) begin
      idx     <= '0;
      miso    <= 1'b0;
      miso_oe <= 1'b0;
    end else if (sclk_fall && rd_phase) begin
      miso_oe <= 1'b1;
      if (idx == 3'd0) begin
        snap <= status_live;
        miso <= status_live[7];
      end else begin
        miso <= snap[~idx];
      end
      idx <= idx + 3'd1;
    end
  end

endmodule

// File: rtl/spi_erase_timer.sv
module spi_erase_timer #(
  parameter int CYCLES = 100000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);

  localparam int CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (!busy) begin
      if (start) begin
        busy <= 1'b1;
        cnt  <= CW'(CYCLES - 1);
      end
    end else if (cnt == '0) begin
      busy <= 1'b0;
    end else begin
      cnt <= cnt - 1'b1;
    end
  end

  assign done = busy && (cnt == '0);

endmodule

// File: rtl/spi_erase_ctl.sv
module spi_erase_ctl
  import spi_erase_pkg::*;
#(
  parameter int BLK_W        = 4,
  parameter int ERASE_CYCLES = 100000,
  parameter int SYNC_STAGES  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             spi_sclk,
  input  logic             spi_cs_n,
  input  logic             spi_mosi,
  input  logic [5:0]       prot_cfg,
  output logic             spi_miso,
  output logic             spi_miso_oe,
  output logic             erase_strobe,
  output logic [BLK_W-1:0] erase_blk
);

  localparam int CNT_W = 6;

  // Synchronised pins: index 0 serial clock, 1 chip select, 2 data.
  logic [2:0] pins_s;
  spi_erase_sync #(.N(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({spi_mosi, spi_cs_n, spi_sclk}),
    .dout (pins_s)
  );

  logic sclk_d, cs_n_d;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d <= 1'b0;
      cs_n_d <= 1'b1;
    end else begin
      sclk_d <= pins_s[0];
      cs_n_d <= pins_s[1];
    end
  end

  // Named internal events
  logic sclk_rise, sclk_fall, cs_fall_ev, cs_rise_ev, cs_low;
  assign sclk_rise  = pins_s[0] & ~sclk_d;
  assign sclk_fall  = ~pins_s[0] & sclk_d;
  assign cs_fall_ev = ~pins_s[1] & cs_n_d;
  assign cs_rise_ev = pins_s[1] & ~cs_n_d;
  assign cs_low     = ~pins_s[1];

  logic [CNT_W-1:0] frame_bits;
  logic [7:0]       frame_opc;
  logic [BLK_W-1:0] frame_blk;

  spi_erase_frame #(.BLK_W(BLK_W), .CNT_W(CNT_W)) u_frame (
    .clk      (clk),
    .rst_n    (rst_n),
    .sclk_rise(sclk_rise),
    .cs_fall  (cs_fall_ev),
    .cs_low   (cs_low),
    .mosi     (pins_s[2]),
    .bit_cnt  (frame_bits),
    .opc      (frame_opc),
    .blk      (frame_blk)
  );

  logic busy, erase_done, wel_q;
  logic blk_prot, erase_req, erase_start, wen_accept, rd_phase;

  assign blk_prot    = blk_locked(8'(frame_blk), prot_t'(prot_cfg), BLK_W);
  assign erase_req   = cs_rise_ev && (frame_opc == OPC_ERASE)
                       && (frame_bits == CNT_W'(ERASE_FRAME_BITS));
  assign erase_start = erase_req && wel_q && !busy && !blk_prot;
  assign wen_accept  = cs_rise_ev && (frame_opc == OPC_WEN)
                       && (frame_bits == CNT_W'(WEN_FRAME_BITS)) && !busy;
  assign rd_phase    = (frame_opc == OPC_RDSR) && (frame_bits >= CNT_W'(8));

  spi_erase_timer #(.CYCLES(ERASE_CYCLES)) u_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .start(erase_start),
    .busy (busy),
    .done (erase_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel_q        <= 1'b0;
      erase_strobe <= 1'b0;
      erase_blk    <= '0;
    end else begin
      if (erase_done)      wel_q <= 1'b0;
      else if (wen_accept) wel_q <= 1'b1;
      erase_strobe <= erase_start;
      if (erase_start) erase_blk <= frame_blk;
    end
  end

  spi_erase_tx u_tx (
    .clk        (clk),
    .rst_n      (rst_n),
    .sclk_fall  (sclk_fall),
    .cs_low     (cs_low),
    .rd_phase   (rd_phase),
    .status_live(status_byte(busy, wel_q)),
    .miso       (spi_miso),
    .miso_oe    (spi_miso_oe)
  );

endmodule

// File: rtl/spi_erase_chk.sv
module spi_erase_chk
  import spi_erase_pkg::*;
#(
  parameter int BLK_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             erase_strobe,
  input logic [BLK_W-1:0] erase_blk,
  input logic             wel,
  input logic             busy,
  input logic [5:0]       prot_cfg,
  input logic             spi_miso_oe,
  input logic             cs_rise_ev
);

  AST_STROBE_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
    erase_strobe |-> wel);  // R6

  AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    erase_strobe |=> !erase_strobe);  // R4

  AST_STROBE_OPENS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    erase_strobe |-> busy && !$past(busy));  // R8

  AST_STROBE_UNPROTECTED: assert property (@(posedge clk) disable iff (!rst_n)
    erase_strobe |-> !blk_locked(8'(erase_blk), prot_t'($past(prot_cfg)), BLK_W));  // R7

  AST_WEL_CLEAR_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !wel);  // R8

  AST_BLK_HOLD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(erase_blk));  // R9

  AST_OE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    cs_rise_ev |=> !spi_miso_oe);  // R3

endmodule

bind spi_erase_ctl spi_erase_chk #(.BLK_W(BLK_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .erase_strobe(erase_strobe),
  .erase_blk   (erase_blk),
  .wel         (wel_q),
  .busy        (busy),
  .prot_cfg    (prot_cfg),
  .spi_miso_oe (spi_miso_oe),
  .cs_rise_ev  (cs_rise_ev)
);

// File: tb/spi_erase_ctl_tb_top.sv
`timescale 1ns/1ps
module spi_erase_ctl_tb_top;

  localparam int BLK_W  = 4;
  localparam int ERASE  = 2000;
  localparam int HALF   = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic spi_sclk = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0;
  logic [5:0] prot_cfg = '0;
  logic spi_miso, spi_miso_oe, erase_strobe;
  logic [BLK_W-1:0] erase_blk;

  always #5 clk = ~clk;

  spi_erase_ctl #(.BLK_W(BLK_W), .ERASE_CYCLES(ERASE)) dut_i (
    .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .prot_cfg(prot_cfg), .spi_miso(spi_miso),
    .spi_miso_oe(spi_miso_oe), .erase_strobe(erase_strobe), .erase_blk(erase_blk)
  );

  int checks = 0;
  int fails  = 0;
  int strobe_cnt = 0;
  logic [BLK_W-1:0] last_blk = '0;

  always @(negedge clk) begin
    if (rst_n && erase_strobe) begin
      strobe_cnt <= strobe_cnt + 1;
      last_blk   <= erase_blk;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_h();
    repeat (HALF) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    spi_cs_n = 1'b1;
    spi_sclk = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // Sends nbits of word MSB first, then nread clocks capturing MISO.
  task automatic spi_frame(input bit mode3, input int nbits, input logic [31:0] word,
                           input int nread, output logic [15:0] rd, output bit oe_ok);
    rd = '0;
    oe_ok = 1'b1;
    spi_sclk = mode3;
    wait_h();
    spi_cs_n = 1'b0;
    wait_h();
    for (int i = 0; i < nbits + nread; i++) begin
      spi_sclk = 1'b0;
      spi_mosi = (i < nbits && i < 32) ? word[31-i] : 1'b0;
      wait_h();
      spi_sclk = 1'b1;
      if (i >= nbits) begin
        rd = {rd[14:0], spi_miso};
        oe_ok = oe_ok & spi_miso_oe;
      end
      wait_h();
    end
    if (!mode3) spi_sclk = 1'b0;
    wait_h();
    spi_cs_n = 1'b1;
    repeat (4) wait_h();
  endtask

  task automatic send(input bit mode3, input int nbits, input logic [31:0] word);
    logic [15:0] rd;
    bit ok;
    spi_frame(mode3, nbits, word, 0, rd, ok);
  endtask

  task automatic read_status(input bit mode3, output logic [7:0] st);
    logic [15:0] rd;
    bit ok;
    spi_frame(mode3, 8, 32'h0500_0000, 8, rd, ok);
    st = rd[7:0];
  endtask

  typedef struct packed {
    logic [5:0]  prot;
    logic        wen;
    logic        mode3;
    logic [6:0]  nbits;
    logic [31:0] word;
    logic        go;
    logic [3:0]  blk;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{6'h00, 1'b1, 1'b0, 7'd32, 32'hD805_1234, 1'b1, 4'h5},  // R4
    '{6'h00, 1'b1, 1'b1, 7'd32, 32'hD80A_0000, 1'b1, 4'hA},  // R10
    '{6'h00, 1'b0, 1'b0, 7'd32, 32'hD803_0000, 1'b0, 4'h0},  // R6
    '{6'h00, 1'b1, 1'b0, 7'd31, 32'hD803_0000, 1'b0, 4'h0},  // R5
    '{6'h00, 1'b1, 1'b1, 7'd33, 32'hD803_0000, 1'b0, 4'h0},  // R5
    '{6'h00, 1'b1, 1'b0, 7'd24, 32'hD803_0000, 1'b0, 4'h0},  // R5
    '{6'h01, 1'b1, 1'b0, 7'd32, 32'hD80F_0000, 1'b0, 4'h0},  // R7 top 1
    '{6'h01, 1'b1, 1'b0, 7'd32, 32'hD80E_0000, 1'b1, 4'hE},  // R7
    '{6'h0B, 1'b1, 1'b0, 7'd32, 32'hD803_0000, 1'b0, 4'h0},  // R7 bottom 4
    '{6'h0B, 1'b1, 1'b0, 7'd32, 32'hD804_0000, 1'b1, 4'h4},  // R7
    '{6'h2B, 1'b1, 1'b0, 7'd32, 32'hD803_0000, 1'b1, 4'h3},  // R7 complement
    '{6'h2B, 1'b1, 1'b0, 7'd32, 32'hD804_0000, 1'b0, 4'h0},  // R7
    '{6'h11, 1'b1, 1'b0, 7'd32, 32'hD80F_0000, 1'b0, 4'h0},  // R7 sector
    '{6'h07, 1'b1, 1'b0, 7'd32, 32'hD800_0000, 1'b0, 4'h0},  // R7 all
    '{6'h00, 1'b1, 1'b0, 7'd32, 32'h2005_0000, 1'b0, 4'h0},  // R11
    '{6'h00, 1'b1, 1'b1, 7'd32, 32'hD8F7_0000, 1'b1, 4'h7},  // R4 upper bits
    '{6'h11, 1'b1, 1'b0, 7'd32, 32'hD800_0000, 1'b1, 4'h0}   // R7 sector
  };

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : main
    logic [7:0] st;
    logic [15:0] rd;
    bit ok;
    int c0;

    // R1 reset state
    do_reset();
    check(spi_miso_oe == 1'b0, "R1 oe after reset", 32'(spi_miso_oe), 0);
    read_status(1'b0, st);
    check(st == 8'h00, "R1 status after reset", 32'(st), 0);
    check(strobe_cnt == 0, "R1 no strobe", 32'(strobe_cnt), 0);

    // R2 write enable exact length
    send(1'b0, 9, 32'h0600_0000);
    read_status(1'b0, st);
    check(st == 8'h00, "R2 nine-bit 06h ignored", 32'(st), 0);
    send(1'b0, 7, 32'h0600_0000);
    read_status(1'b0, st);
    check(st == 8'h00, "R2 seven-bit 06h ignored", 32'(st), 0);
    send(1'b0, 8, 32'h0600_0000);
    read_status(1'b1, st);
    check(st == 8'h02, "R2 06h sets flag (R10 mode 3 read)", 32'(st), 32'h02);

    // R3 repeating byte and output enable
    spi_frame(1'b0, 8, 32'h0500_0000, 16, rd, ok);
    check(rd == 16'h0202, "R3 status byte repeats", 32'(rd), 32'h0202);
    check(ok, "R3 oe high while driving", 32'(ok), 1);
    check(spi_miso_oe == 1'b0, "R3 oe low after frame", 32'(spi_miso_oe), 0);

    // Vector table
    for (int k = 0; k < NV; k++) begin
      do_reset();
      prot_cfg = VECS[k].prot;
      if (VECS[k].wen) send(1'b0, 8, 32'h0600_0000);
      c0 = strobe_cnt;
      send(VECS[k].mode3, int'(VECS[k].nbits), VECS[k].word);
      check((strobe_cnt - c0) == int'(VECS[k].go),
            $sformatf("R4/R5/R6/R7/R11 vector %0d strobe count", k),
            32'(strobe_cnt - c0), 32'(VECS[k].go));
      if (VECS[k].go)
        check(last_blk == VECS[k].blk, $sformatf("R4 vector %0d block", k),
              32'(last_blk), 32'(VECS[k].blk));
      read_status(VECS[k].mode3, st);
      check(st == {6'b0, VECS[k].wen, VECS[k].go},
            $sformatf("R5/R6/R7/R8 vector %0d status", k), 32'(st),
            32'({6'b0, VECS[k].wen, VECS[k].go}));
      if (VECS[k].go) begin
        repeat (ERASE + 200) @(negedge clk);
        read_status(1'b0, st);
        check(st == 8'h00, $sformatf("R8 vector %0d status after erase", k), 32'(st), 0);
      end
    end

    // R9 commands during busy
    do_reset();
    prot_cfg = 6'h00;
    send(1'b0, 8, 32'h0600_0000);
    send(1'b0, 32, 32'hD809_0000);
    c0 = strobe_cnt;
    send(1'b0, 32, 32'hD802_0000);
    check(strobe_cnt == c0, "R9 second erase ignored", 32'(strobe_cnt), 32'(c0));
    check(erase_blk == 4'h9, "R9 block held", 32'(erase_blk), 32'h9);
    read_status(1'b0, st);
    check(st == 8'h03, "R8/R9 busy readable mid-erase", 32'(st), 32'h03);
    repeat (ERASE) @(negedge clk);
    read_status(1'b0, st);
    check(st == 8'h00, "R8 busy and flag cleared", 32'(st), 0);
    send(1'b0, 32, 32'hD802_0000);
    check(strobe_cnt == c0, "R8 erase refused after flag clear", 32'(strobe_cnt), 32'(c0));

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule